// File: doc/BRIEF.md
# Delayed-switchover CPU clock selector

This block decides which clock paces the CPU. There are two choices. One is a fast main clock divided by a power of two from 1 to 16. The other is a slow subsystem clock. Software writes one control register to pick the source and the divider.

A new setting does not take effect when it is written. The block keeps running on the old setting for a number of CPU clocks that depends on that old setting, and then applies the new one. A read-only status bit shows which source is actually in use. It changes only when a switchover completes.

Both sources reach the block as single-cycle enable strobes in one reference clock domain. The output is a CPU clock-enable pulse in that same domain.

Register fields:

| Bits | Field | Access | Meaning |
|------|-------|--------|---------|
| 2:0 | division code | read/write | codes 0 to 4 divide the main clock by 1, 2, 4, 8, 16; codes 5 to 7 are reserved |
| 4 | requested source | read/write | 0 = main, 1 = subsystem |
| 5 | applied source | read-only | source the CPU clock currently runs on |
| 6 | sticky error | read-only | set by a forbidden write, cleared only by reset |
| 3, 7 | unused | read-only | always read 0 |

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset, the register reads 8'h04 (main source, division code 4, status 0, no error) and no switchover is pending.
- R2: While the main source is applied with code k (0 to 4), `cpu_ce` pulses once for every 2^k main strobes, one cycle after the strobe that completes the group. `cpu_ce` never pulses in the cycle after a cycle with no main strobe.
- R3: While the subsystem source is applied, `cpu_ce` pulses in the cycle after each subsystem strobe.
- R4: For a change that keeps the main source, the new setting is applied after 16, 8, 4, 2 or 1 `cpu_ce` pulses when the old code is 0, 1, 2, 3 or 4.
- R5: When the old source is the subsystem clock, every change is applied after 2 `cpu_ce` pulses.
- R6: A main-to-sub switch from old code k is applied after ceil(2·MAIN_HZ / (SUB_HZ·2^k)) `cpu_ce` pulses.
- R7: Bit 5 changes only in the cycle after the final wait pulse, never at the write itself.
- R8: A write whose bits 2:0 hold a reserved code (5, 6 or 7) leaves the division code unchanged. The source bit of that write is still taken.
- R9: A write that asks for main-to-sub and also changes the division code relative to the current register value is forbidden. The block then sets bit 6 and keeps the requested source at main, while the new code is still accepted. A sub-to-main write that also changes the code is allowed.
- R10: A write made while a switchover is pending restarts the full wait, measured from the applied setting, toward the newest value. A write equal to the applied setting cancels the pending change.
- R11: Reading returns the division code in bits 2:0, the requested source in bit 4, the applied source in bit 5 and the error flag in bit 6. Bits 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Enable strobe of the main clock |
| sub_tick | input | 1 | Enable strobe of the subsystem clock |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| cpu_ce | output | 1 | CPU clock-enable pulse |

## Verification
Main-to-sub switches are tried from division codes 0 and 2. The two codes give different rounded wait counts, and this separates a scaled ratio from a fixed one and a rounded-up result from a truncated one.

Sub-to-main writes are tried with a reserved code and with a code change. These two patterns separate the 2-pulse wait from a wait that depends on the code, and they also confirm that such writes set no error.

A repeated write during a pending switch must show a restarted full wait rather than the remaining count. A write-then-revert pair must show the pending change cancelled.

Main-strobe density and subsystem-strobe spacing differ throughout the run. A bench model compared every cycle separates output timing that is driven by the strobes from timing driven by the reference clock.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int CODE_W   = 3;
  localparam int CODE_MAX = 4;
  localparam int NCODES   = CODE_MAX + 1;
  localparam int DCNT_W   = CODE_MAX;
  localparam int SUB_OLD_WAIT = 2;

  typedef logic [CODE_W-1:0] div_code_t;

  typedef struct packed {
    logic      src;
    div_code_t code;
  } clk_sel_t;

  function automatic longint ceil_ratio(longint fm, longint fs, int code);
    longint den;
    den = fs << code;
    return (2 * fm + den - 1) / den;
  endfunction

  function automatic int main_wait(int code);
    return (1 << CODE_MAX) >> code;
  endfunction
endpackage

// File: rtl/clksw_ctrl_reg.sv
module clksw_ctrl_reg
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output clk_sel_t   req,
  output clk_sel_t   req_nxt,
  output logic       err
);
  logic      code_ok;
  logic      bad_wr;
  div_code_t new_code;

  always_comb begin
    code_ok  = (wr_data[CODE_W-1:0] <= div_code_t'(CODE_MAX));
    new_code = code_ok ? wr_data[CODE_W-1:0] : req.code;
    bad_wr   = !req.src && wr_data[4] && (new_code != req.code);
    req_nxt.code = new_code;
    req_nxt.src  = bad_wr ? 1'b0 : wr_data[4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req.src  <= 1'b0;
      req.code <= div_code_t'(CODE_MAX);
      err      <= 1'b0;
    end else if (wr_en) begin
      req <= req_nxt;
      if (bad_wr) err <= 1'b1;
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_code_legal_r8: assert property (@(posedge clk) disable iff (rst)
    req.code <= div_code_t'(CODE_MAX));

  p_reserved_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[2:0] > 3'd4) |=> $stable(req.code));
endmodule

// File: rtl/clksw_switch_seq.sv
module clksw_switch_seq
  import clksw_pkg::*;
#(
  parameter longint MAIN_HZ = 10_000_000,
  parameter longint SUB_HZ  = 32_768
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_fire,
  input  clk_sel_t tgt_nxt,
  input  clk_sel_t tgt_cur,
  input  logic     cpu_ce,
  output clk_sel_t app,
  output logic     apply_now
);
  localparam longint SUB_WAIT_MAX = ceil_ratio(MAIN_HZ, SUB_HZ, 0);
  localparam longint WAIT_MAX = (SUB_WAIT_MAX > 16) ? SUB_WAIT_MAX : 16;
  localparam int CW = $clog2(WAIT_MAX + 1);

  logic [CW-1:0] sub_wait [NCODES];
  logic [CW-1:0] main_wt  [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_wait
    assign sub_wait[g] = CW'(ceil_ratio(MAIN_HZ, SUB_HZ, g));
    assign main_wt[g]  = CW'(main_wait(g));
  end

  logic          pending;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;
  logic          differs;

  always_comb begin
    if (app.src)
      load_val = CW'(SUB_OLD_WAIT);
    else if (tgt_nxt.src)
      load_val = sub_wait[app.code];
    else
      load_val = main_wt[app.code];
    differs   = (tgt_nxt != app);
    apply_now = pending && cpu_ce && (cnt == CW'(1)) && !wr_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      app.src  <= 1'b0;
      app.code <= div_code_t'(CODE_MAX);
      pending  <= 1'b0;
      cnt      <= '0;
    end else if (wr_fire) begin
      pending <= differs;
      cnt     <= differs ? load_val : '0;
    end else if (pending && cpu_ce) begin
      if (cnt == CW'(1)) begin
        app     <= tgt_cur;
        pending <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  p_status_on_apply_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(app.src) |-> $past(pending));

  p_pending_count_r6: assert property (@(posedge clk) disable iff (rst)
    pending |-> (cnt != '0));

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && (tgt_nxt != app)) |=> pending);

  p_hold_while_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (pending && !cpu_ce) |=> $stable(app));
endmodule

// File: rtl/clksw_ce_gen.sv
module clksw_ce_gen
  import clksw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     main_tick,
  input  logic     sub_tick,
  input  clk_sel_t app,
  input  logic     apply_now,
  output logic     cpu_ce
);
  logic [DCNT_W-1:0] dcnt;
  logic [DCNT_W-1:0] lim;
  logic              grp_done;

  always_comb begin
    lim      = DCNT_W'((1 << app.code) - 1);
    grp_done = main_tick && (dcnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt   <= '0;
      cpu_ce <= 1'b0;
    end else begin
      cpu_ce <= app.src ? sub_tick : grp_done;
      if (apply_now)
        dcnt <= '0;
      else if (!app.src && main_tick)
        dcnt <= grp_done ? '0 : dcnt + DCNT_W'(1);
    end
  end

  p_sub_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (app.src && sub_tick) |=> cpu_ce);

  p_main_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (!app.src && !main_tick) |=> !cpu_ce);
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import clksw_pkg::*;
#(
  parameter longint MAIN_HZ = 10_000_000,
  parameter longint SUB_HZ  = 32_768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       cpu_ce
);
  clk_sel_t req;
  clk_sel_t req_nxt;
  clk_sel_t app;
  logic     err;
  logic     apply_now;

  clksw_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req     (req),
    .req_nxt (req_nxt),
    .err     (err)
  );

  clksw_switch_seq #(.MAIN_HZ(MAIN_HZ), .SUB_HZ(SUB_HZ)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_en),
    .tgt_nxt   (req_nxt),
    .tgt_cur   (req),
    .cpu_ce    (cpu_ce),
    .app       (app),
    .apply_now (apply_now)
  );

  clksw_ce_gen u_ce (
    .clk       (clk),
    .rst       (rst),
    .main_tick (main_tick),
    .sub_tick  (sub_tick),
    .app       (app),
    .apply_now (apply_now),
    .cpu_ce    (cpu_ce)
  );

  assign rd_data = {1'b0, err, app.src, req.src, 1'b0, req.code};
endmodule

// File: tb/sim_cpu_clk_switch.sv
module sim_cpu_clk_switch;
  localparam longint FM = 1000;
  localparam longint FS = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cpu_ce;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int main_per = 2;
  int sub_per = 5;
  string phase = "R1";

  always #5 clk = ~clk;

  cpu_clk_switch #(.MAIN_HZ(FM), .SUB_HZ(FS)) u0 (
    .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cpu_ce(cpu_ce)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------- behavioural reference model ----------
  int  m_rcode, m_rsrc, m_acode, m_asrc, m_err, m_pend, m_cnt, m_dcnt, m_ce;

  function automatic int wait_of(int asrc, int acode, int tsrc);
    if (asrc == 1) return 2;
    if (tsrc == 1) return int'((2 * FM + (FS * (64'd1 << acode)) - 1) / (FS * (64'd1 << acode)));
    return 16 / (1 << acode);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rcode = 4; m_rsrc = 0; m_acode = 4; m_asrc = 0;
      m_err = 0; m_pend = 0; m_cnt = 0; m_dcnt = 0; m_ce = 0;
    end else begin
      int  n_ce, lim, nc, ns;
      bit  apply;
      lim   = (1 << m_acode) - 1;
      apply = m_pend && m_ce && m_cnt == 1 && !wr_en;
      n_ce  = m_asrc ? int'(sub_tick) : int'(main_tick && m_dcnt == lim);
      if (apply) m_dcnt = 0;
      else if (m_asrc == 0 && main_tick) m_dcnt = (m_dcnt == lim) ? 0 : m_dcnt + 1;
      if (wr_en) begin
        nc = (wr_data[2:0] <= 4) ? int'(wr_data[2:0]) : m_rcode;
        ns = int'(wr_data[4]);
        if (m_rsrc == 0 && ns == 1 && nc != m_rcode) begin
          m_err = 1; ns = 0;
        end
        if (nc != m_acode || ns != m_asrc) begin
          m_pend = 1; m_cnt = wait_of(m_asrc, m_acode, ns);
        end else begin
          m_pend = 0; m_cnt = 0;
        end
        m_rcode = nc; m_rsrc = ns;
      end else if (m_pend && m_ce) begin
        if (m_cnt == 1) begin
          m_acode = m_rcode; m_asrc = m_rsrc; m_pend = 0; m_cnt = 0;
        end else m_cnt = m_cnt - 1;
      end
      m_ce = n_ce;
    end
  end

  // stimulus strobes and per-cycle comparison, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check({phase, " cpu_ce"}, int'(cpu_ce), m_ce);
      check({phase, " rd_data (R11)"}, int'(rd_data),
            (m_err << 6) | (m_asrc << 5) | (m_rsrc << 4) | m_rcode);
    end
    main_tick = (cyc % main_per) == 0;
    sub_tick  = (cyc % sub_per) == 0;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses_to_switch(output int n);
    logic prev;
    n = 0;
    prev = rd_data[5];
    for (int i = 0; i < 5000; i++) begin
      if (rd_data[5] != prev) break;
      if (cpu_ce) n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset readback", int'(rd_data), 8'h04);
    idle(120);
    phase = "R2";
    main_per = 1;
    idle(80);
    phase = "R4";
    wr(8'h00);
    idle(120);
    phase = "R9";
    wr(8'h12);
    check("R9 forbidden write sets error, keeps main", int'(rd_data), 8'h42);
    idle(60);
    phase = "R6";
    wr(8'h12);
    pulses_to_switch(n);
    check("R6 main-to-sub wait from code 2", n, 2);
    check("R7 status after switch", int'(rd_data[5]), 1);
    phase = "R3";
    idle(80);
    phase = "R8";
    wr(8'h05);
    pulses_to_switch(n);
    check("R5 sub-to-main wait", n, 2);
    check("R8 reserved code kept", int'(rd_data), 8'h42);
    phase = "R10";
    wr(8'h10);
    for (int i = 0; i < 500 && !cpu_ce; i++) @(negedge clk);
    @(negedge clk);
    wr(8'h10);
    pulses_to_switch(n);
    check("R10 restart gives full wait", n, 2);
    sub_per = 3;
    idle(40);
    phase = "R9";
    wr(8'h03);
    pulses_to_switch(n);
    check("R9 sub-to-main with code change wait", n, 2);
    check("R9 sub-to-main with code change allowed", int'(rd_data), 8'h43);
    phase = "R4";
    main_per = 2;
    wr(8'h00);
    idle(100);
    phase = "R6";
    wr(8'h10);
    pulses_to_switch(n);
    check("R6 main-to-sub wait from code 0", n, 7);
    idle(30);
    wr(8'h00);
    pulses_to_switch(n);
    check("R5 back to main", n, 2);
    phase = "R10";
    wr(8'h01);
    wr(8'h00);
    idle(60);
    check("R10 cancelled change readback", int'(rd_data), 8'h40);
    phase = "R2";
    main_per = 3;
    wr(8'h02);
    idle(150);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule